// File: doc/BRIEF.md
# Flash and Torch Mode Sequencer with Flash Time Budget

This block decides the operating state of a single-LED flash driver from a few command fields, an external trigger input and fault inputs. It reports one of four states (off, ready, torch, flash) and picks the 4-bit current code the analog side should use. Analog current regulation and the power converter are handled elsewhere.

Flash is requested when power is enabled, the trigger-enable field is set and the trigger pin is high. Flash is limited by a budget timer. The timer loads from the 4-bit timeout field whenever the command register is written. It counts down one step per tick while flash is active, where a tick is a configurable number of clocks (100 ms in silicon). The remaining budget is kept across separate trigger pulses. When the budget runs out, the block ends the flash, raises a one-cycle alert, and asks the register owner to clear the trigger-enable bit. The timeout field itself is left as it was.

Top module: `flash_mode_ctrl`

## Requirements
- R1: With `pwrOn` low, `mode` is 0 (off) and `dimCode` is 0.
- R2: With `pwrOn` high and neither flash nor torch active, `mode` is 1 (ready) and `dimCode` is 0. With `torchOn` high and no flash, `mode` is 2 (torch) and `dimCode` equals `torchDim`.
- R3: Flash is requested by `pwrOn & trigEn & trigPin`. When that request is present and budget remains, `mode` is 3 (flash), even if `torchOn` is set.
- R4: In flash mode `dimCode` equals `flashDim`, unless R5 applies.
- R5: In flash mode with `txMask` high and `flashDim[3]` set, `dimCode` is the `MASK_CODE` parameter (default 7). With `flashDim[3]` clear, `txMask` has no effect.
- R6: The budget is `flashTimeout` ticks. It drops by one after every `TICK_CYCLES` clocks spent in flash. A budget of N allows exactly N*`TICK_CYCLES` flash cycles, summed over all trigger pulses.
- R7: The budget and the partial-tick count are reloaded only by `cmdWrite`. Releasing and re-asserting the trigger does not reload them.
- R8: When flash is requested with zero budget, `mode` does not enter flash. `timeoutEvent` and `trigEnClear` pulse high for exactly one cycle. They pulse again only after a new `cmdWrite`. A loaded timeout of 0 therefore ends a flash on its first cycle.
- R9: `faultAbort` high with `pwrOn` high forces `mode` to 1 (ready) from torch or flash. The budget does not advance during the abort.
- R10: `flashRunning` is high exactly when `mode` is 3.
- R11: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWrite | input | 1 | One-cycle strobe on a command register write; reloads the budget |
| pwrOn | input | 1 | Power enable field |
| trigEn | input | 1 | Trigger enable field |
| torchOn | input | 1 | Torch request field |
| flashTimeout | input | 4 | Flash budget in ticks |
| trigPin | input | 1 | External trigger pin, synchronous |
| faultAbort | input | 1 | OR of open-LED, LED overheat and chip overtemperature faults |
| txMask | input | 1 | Transmit mask; reduces high flash current |
| flashDim | input | 4 | Flash current code |
| torchDim | input | 4 | Torch current code |
| mode | output | 2 | 0 off, 1 ready, 2 torch, 3 flash |
| dimCode | output | 4 | Selected current code |
| flashRunning | output | 1 | Flash active |
| timeoutEvent | output | 1 | One-cycle alert on budget exhaustion |
| trigEnClear | output | 1 | One-cycle request to clear the trigger enable field |

## Verification
The bench targets budget carry-over across several trigger pulses. A design that reloads on every trigger edge would flash for longer than N ticks in total. A zero timeout is also exercised: a design that checks for zero only after decrementing would give one stray flash cycle or wrap around to 15. The bench holds the trigger after expiry to catch alerts that repeat every cycle. It also drives the mask with the flash code's top bit clear, and faults during flash, where a wrong design would keep counting the budget or stay in flash.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_READY = 2'd1,
    MODE_TORCH = 2'd2,
    MODE_FLASH = 2'd3
  } led_mode_e;

  // Strobes from the control to the budget datapath
  typedef struct packed {
    logic load;     // reload budget from the timeout field
    logic advance;  // one cycle of flash spent
  } budget_strobe_t;
endpackage

// File: rtl/flash_budget_dp.sv
module flash_budget_dp
  import flash_mode_pkg::*;
#(
  parameter int TIMER_W     = 4,
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  budget_strobe_t     strobe,
  input  logic [TIMER_W-1:0] loadValue,
  output logic               remainZero
);
  localparam int PRE_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]   preCnt;
  logic [TIMER_W-1:0] remain;
  logic               tickDone;

  assign tickDone   = strobe.advance && (preCnt == PRE_LAST);
  assign remainZero = (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      remain <= '0;
    end else if (strobe.load) begin
      preCnt <= '0;
      remain <= loadValue;
    end else if (strobe.advance) begin
      if (tickDone) begin
        preCnt <= '0;
        remain <= remain - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  AST_BUDGET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.advance) |=> ($stable(remain) && $stable(preCnt))); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (remainZero && !strobe.load) |=> remainZero); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !remainZero) |=> (remain == $past(remain) || remain == $past(remain) - 1'b1)); // R6
endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import flash_mode_pkg::*;
#(
  parameter int DIM_W = 4,
  parameter logic [DIM_W-1:0] MASK_CODE = 4'd7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic             pwrOn,
  input  logic             trigEn,
  input  logic             torchOn,
  input  logic             trigPin,
  input  logic             faultAbort,
  input  logic             txMask,
  input  logic [DIM_W-1:0] flashDim,
  input  logic [DIM_W-1:0] torchDim,
  input  logic             remainZero,
  output budget_strobe_t   strobe,
  output logic [1:0]       mode,
  output logic [DIM_W-1:0] dimCode,
  output logic             flashRunning,
  output logic             timeoutEvent,
  output logic             trigEnClear
);
  logic      flashReq, flashGo, expire, spent;
  led_mode_e nextMode;
  logic [DIM_W-1:0] nextDim, flashCode;

  assign flashReq  = pwrOn && !faultAbort && trigEn && trigPin;
  assign flashGo   = flashReq && !remainZero;
  assign expire    = flashReq && remainZero && !spent;
  assign flashCode = (txMask && flashDim[DIM_W-1]) ? MASK_CODE : flashDim;

  assign strobe.load    = cmdWrite;
  assign strobe.advance = flashGo;

  always_comb begin
    nextMode = MODE_READY;
    nextDim  = '0;
    if (!pwrOn) begin
      nextMode = MODE_OFF;
    end else if (faultAbort) begin
      nextMode = MODE_READY;
    end else if (flashGo) begin
      nextMode = MODE_FLASH;
      nextDim  = flashCode;
    end else if (torchOn) begin
      nextMode = MODE_TORCH;
      nextDim  = torchDim;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode         <= MODE_OFF;
      dimCode      <= '0;
      flashRunning <= 1'b0;
      timeoutEvent <= 1'b0;
      trigEnClear  <= 1'b0;
      spent        <= 1'b0;
    end else begin
      mode         <= nextMode;
      dimCode      <= nextDim;
      flashRunning <= flashGo;
      timeoutEvent <= expire;
      trigEnClear  <= expire;
      if (cmdWrite)    spent <= 1'b0;
      else if (expire) spent <= 1'b1;
    end
  end

  AST_OFF_WHEN_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> (mode == MODE_OFF && dimCode == '0)); // R1

  AST_FAULT_TO_READY: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOn && faultAbort) |=> (mode == MODE_READY)); // R9

  AST_ALERT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvent && !$past(cmdWrite)) |=> !timeoutEvent); // R8

  AST_RUN_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rstN)
    flashRunning == (mode == MODE_FLASH)); // R10

  AST_ALERT_NO_FLASH: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvent |-> (mode != MODE_FLASH)); // R8
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
#(
  parameter int TIMER_W     = 4,
  parameter int DIM_W       = 4,
  parameter int TICK_CYCLES = 25_000_000,
  parameter logic [DIM_W-1:0] MASK_CODE = 4'd7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrite,
  input  logic               pwrOn,
  input  logic               trigEn,
  input  logic               torchOn,
  input  logic [TIMER_W-1:0] flashTimeout,
  input  logic               trigPin,
  input  logic               faultAbort,
  input  logic               txMask,
  input  logic [DIM_W-1:0]   flashDim,
  input  logic [DIM_W-1:0]   torchDim,
  output logic [1:0]         mode,
  output logic [DIM_W-1:0]   dimCode,
  output logic               flashRunning,
  output logic               timeoutEvent,
  output logic               trigEnClear
);
  budget_strobe_t strobe;
  logic           remainZero;

  flash_mode_fsm #(.DIM_W(DIM_W), .MASK_CODE(MASK_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .pwrOn(pwrOn),
    .trigEn(trigEn), .torchOn(torchOn), .trigPin(trigPin),
    .faultAbort(faultAbort), .txMask(txMask), .flashDim(flashDim),
    .torchDim(torchDim), .remainZero(remainZero), .strobe(strobe),
    .mode(mode), .dimCode(dimCode), .flashRunning(flashRunning),
    .timeoutEvent(timeoutEvent), .trigEnClear(trigEnClear)
  );

  flash_budget_dp #(.TIMER_W(TIMER_W), .TICK_CYCLES(TICK_CYCLES)) uBudget (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(flashTimeout),
    .remainZero(remainZero)
  );
endmodule

// File: tb/tb_flash_mode_ctrl.sv
module tb_flash_mode_ctrl;
  localparam int TICK = 4;
  localparam logic [3:0] MASKC = 4'd7;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWrite = 0, pwrOn = 0, trigEn = 0, torchOn = 0, trigPin = 0;
  logic faultAbort = 0, txMask = 0;
  logic [3:0] flashTimeout = 0, flashDim = 0, torchDim = 0;
  logic [1:0] mode;
  logic [3:0] dimCode;
  logic flashRunning, timeoutEvent, trigEnClear;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;

  // reference state
  int mRemain = 0, mPre = 0;
  bit mSpent = 0;
  logic [1:0] eMode = 0;
  logic [3:0] eDim = 0;
  bit eRun = 0, eEvt = 0;

  always #2 clk = ~clk;  // 250 MHz

  flash_mode_ctrl #(.TICK_CYCLES(TICK), .MASK_CODE(MASKC)) dut (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .pwrOn(pwrOn),
    .trigEn(trigEn), .torchOn(torchOn), .flashTimeout(flashTimeout),
    .trigPin(trigPin), .faultAbort(faultAbort), .txMask(txMask),
    .flashDim(flashDim), .torchDim(torchDim), .mode(mode),
    .dimCode(dimCode), .flashRunning(flashRunning),
    .timeoutEvent(timeoutEvent), .trigEnClear(trigEnClear)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] expFlashDim(logic m, logic [3:0] f);
    return (m && f[3]) ? MASKC : f;  // R5
  endfunction

  // Advance the reference one edge using the inputs now applied
  task automatic modelEdge();
    bit req, go, exp;
    req = pwrOn && !faultAbort && trigEn && trigPin;   // R3
    go  = req && (mRemain != 0);
    exp = req && (mRemain == 0) && !mSpent;            // R8
    if (!pwrOn) begin eMode = 0; eDim = 0; end          // R1
    else if (faultAbort) begin eMode = 1; eDim = 0; end // R9
    else if (go) begin eMode = 3; eDim = expFlashDim(txMask, flashDim); end
    else if (torchOn) begin eMode = 2; eDim = torchDim; end
    else begin eMode = 1; eDim = 0; end                 // R2
    eRun = go;
    eEvt = exp;
    if (cmdWrite) begin mRemain = flashTimeout; mPre = 0; mSpent = 0; end
    else begin
      if (exp) mSpent = 1;
      if (go) begin                                     // R6
        if (mPre == TICK - 1) begin mPre = 0; mRemain--; end
        else mPre++;
      end
    end
  endtask

  // One clock: outputs checked at the following falling edge (R11)
  task automatic step();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check("R2 mode", mode, eMode);
    check("R4 dimCode", dimCode, eDim);
    check("R10 flashRunning", flashRunning, eRun);
    check("R8 timeoutEvent", timeoutEvent, eEvt);
    check("R8 trigEnClear", trigEnClear, eEvt);
    if (trigEnClear) trigEn = 0;  // register owner honours the clear
  endtask

  task automatic writeCmd(bit p, bit te, bit tc, int to);
    pwrOn = p; trigEn = te; torchOn = tc; flashTimeout = 4'(to);
    cmdWrite = 1;
    step();
    cmdWrite = 0;
  endtask

  int flashCount;

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // Reset state (R1)
    check("R1 reset mode", mode, 0);
    check("R1 reset dim", dimCode, 0);
    check("R10 reset run", flashRunning, 0);

    step();
    check("R1 unpowered", mode, 0);
    torchDim = 4'd5; flashDim = 4'd12;
    writeCmd(1, 0, 0, 0);
    step();
    check("R2 ready", mode, 1);
    writeCmd(1, 0, 1, 0);
    step();
    check("R2 torch", mode, 2);
    check("R2 torch dim", dimCode, 5);

    // Budget 2 ticks, trigger held: exactly 2*TICK flash cycles (R6), flash over torch (R3)
    writeCmd(1, 1, 1, 2);
    trigPin = 1;
    flashCount = 0;
    for (int i = 0; i < 20; i++) begin step(); if (flashRunning) flashCount++; end
    check("R6 flash length", flashCount, 2 * TICK);
    check("R3 torch after expiry", mode, 2);
    check("R8 trigEn cleared", trigEn, 0);
    trigPin = 0;

    // Pulses share one budget of 3 ticks (R7)
    writeCmd(1, 1, 0, 3);
    flashCount = 0;
    for (int p = 0; p < 4; p++) begin
      trigPin = 1;
      for (int i = 0; i < 5; i++) begin step(); if (flashRunning) flashCount++; end
      trigPin = 0;
      for (int i = 0; i < 3; i++) step();
    end
    check("R7 budget kept across pulses", flashCount, 3 * TICK);

    // Zero budget ends flash at once (R8)
    writeCmd(1, 1, 0, 0);
    trigPin = 1;
    step();
    check("R8 zero load no flash", mode, 1);
    check("R8 zero load alert", timeoutEvent, 1);
    step();
    check("R8 alert single", timeoutEvent, 0);
    trigPin = 0;

    // Mask (R5) and fault abort (R9)
    writeCmd(1, 1, 0, 15);
    trigPin = 1; txMask = 1; flashDim = 4'd13;
    step(); step();
    check("R5 mask applied", dimCode, 7);
    flashDim = 4'd6;
    step();
    check("R5 mask ignored low code", dimCode, 6);
    faultAbort = 1;
    step();
    check("R9 fault ready", mode, 1);
    faultAbort = 0; txMask = 0; trigPin = 0;
    step();

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 8)
        writeCmd($urandom_range(0, 19) != 0, $urandom_range(0, 2) != 0,
                 $urandom_range(0, 1), $urandom_range(0, 4));
      if ($urandom_range(0, 99) < 20) trigPin = ~trigPin;
      if ($urandom_range(0, 99) < 3)  faultAbort = ~faultAbort;
      if ($urandom_range(0, 99) < 10) txMask = $urandom_range(0, 1);
      if ($urandom_range(0, 99) < 5)  flashDim = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 99) < 5)  torchDim = 4'($urandom_range(0, 15));
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule